// File: doc/BRIEF.md
# Programmable GPIO Port Bank

This block holds a bank of byte-wide general-purpose I/O ports for a microcontroller. Each line has a direction bit and an output latch. Each group of four lines has one pull-up enable bit. A single control bit can force one chosen port to read back its latch. Software reaches all of these through a small synchronous register bus. Writes take effect on the clock edge. Read data is combinational from the address.

On the pad side the block drives, for each line, an output enable, an output value and a pull-up request. It takes the raw pin levels and passes them through a two-flop synchronizer before software can read them. Two inputs from elsewhere in the chip change this behaviour:

- A per-line peripheral override makes a line a driven output whatever its direction bit says.
- A bus-expansion mode input marks a fixed set of lines as external bus pins. While it is asserted, those lines lose their pull-ups and their direction bits cannot be written.

One line in the bank is input-only. It has no driver, no pull-up and no direction bit.

Top module: `gpio_bank`

## Requirements
- R1: After reset every direction bit, latch bit, pull-up bit and the control bit are 0. So `pin_oe` and `pin_pu` are all 0, and reads of the direction, pull-up and control registers return 0.
- R2: For port p, the data register is at address p and the direction register is at NUM_PORTS+p. Pull-up register k is at 2*NUM_PORTS+k, with k running from 0 up to one less than ceil(NUM_PORTS*PORT_W/GROUP_W/PORT_W). The control register comes right after the last pull-up register. Any other address reads 0. Pull-up bits with no group behind them read 0. Control bits other than bit 0 read 0.
- R3: A write to a data register always loads that port's latch, whatever the direction bits. A line whose direction bit is 1 (1 = output, 0 = input) has `pin_oe` high and drives its latch bit on `pin_out`.
- R4: A data register read returns, for each bit, the synchronized pin level when the direction bit is 0 and the latch when it is 1. A pin change is seen in the read after two rising clock edges.
- R5: While bit 0 of the control register is 1, every line of port LATCH_PORT that has a direction bit reads back its latch, whatever its direction.
- R6: Group g covers lines 4g to 4g+3. It is controlled by bit g mod PORT_W of pull-up register g div PORT_W. `pin_pu` is high only on lines of an enabled group whose direction bit is 0. It is never high on a line that is being driven.
- R7: While `exp_mode` is 1, `pin_pu` is 0 on every line in BUS_LINES. The pull-up registers can still be written and read back.
- R8: While `exp_mode` is 1, a direction write leaves the bits of BUS_LINES lines unchanged and updates the other bits.
- R9: A line with `periph_en` high has `pin_oe` high, `pin_out` equal to `periph_out` and `pin_pu` low, whatever its direction bit. Its direction bit and latch are unchanged.
- R10: The line INONLY_LINE has `pin_oe`, `pin_out` and `pin_pu` always 0. Its direction bit always reads 0. Its data bit always returns the synchronized pin level, even under the control-register override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Register address |
| we | input | 1 | Write strobe for one cycle |
| wdata | input | PORT_W | Write data |
| rdata | output | PORT_W | Combinational read data for `addr` |
| exp_mode | input | 1 | External bus expansion mode active |
| periph_en | input | NUM_PORTS*PORT_W | Peripheral output active on each line |
| periph_out | input | NUM_PORTS*PORT_W | Peripheral output value on each line |
| pin_in | input | NUM_PORTS*PORT_W | Raw pad input levels |
| pin_oe | output | NUM_PORTS*PORT_W | Pad output enable |
| pin_out | output | NUM_PORTS*PORT_W | Pad output value |
| pin_pu | output | NUM_PORTS*PORT_W | Pad pull-up request |

## Verification
The bench builds the bank with six ports, so there are 48 lines and twelve pull-up groups. That spills into a second pull-up register whose upper four bits have no group behind them. The bus pins are ports 0 and 1 plus the low half of port 2, so one direction write can be partly locked and partly accepted. Port 1 is the latch-readback port, which makes the readback override meet the locked bus pins. The input-only line is bit 5 of the last port, which lies inside an enabled pull-up group and a writable direction register. The pad model returns a driven value first, then an external drive, then the pull-up level, so every read path and every pull-up gate can be seen from the ports.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_DATA,
        ACC_DIR,
        ACC_PULL,
        ACC_CTRL
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e  kind;
        logic [7:0] idx;
    } acc_dec_t;

    // Address layout: data regs, then direction regs, then pull-up regs, then control
    function automatic acc_dec_t decode_addr(input int unsigned a,
                                             input int unsigned np,
                                             input int unsigned npu);
        acc_dec_t res;
        res.kind = ACC_NONE;
        res.idx  = 8'd0;
        if (a < np) begin
            res.kind = ACC_DATA;
            res.idx  = 8'(a);
        end else if (a < 2 * np) begin
            res.kind = ACC_DIR;
            res.idx  = 8'(a - np);
        end else if (a < 2 * np + npu) begin
            res.kind = ACC_PULL;
            res.idx  = 8'(a - 2 * np);
        end else if (a == 2 * np + npu) begin
            res.kind = ACC_CTRL;
        end
        return res;
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stage1 = raw_i;
        s_d.stage2 = s_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.stage2;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
    parameter int NUM_PORTS   = 4,
    parameter int PORT_W      = 8,
    parameter int GROUP_W     = 4,
    parameter int ADDR_W      = 6,
    parameter logic [NUM_PORTS*PORT_W-1:0] BUS_LINES = 'hFFFF,
    parameter int INONLY_LINE = 29
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic                           we_i,
    input  logic [PORT_W-1:0]              wdata_i,
    input  logic                           exp_mode_i,
    output logic [NUM_PORTS*PORT_W-1:0]    dir_o,
    output logic [NUM_PORTS*PORT_W-1:0]    lat_o,
    output logic [NUM_PORTS*PORT_W/GROUP_W-1:0] pull_o,
    output logic                           ctrl_o
);
    import gpio_bank_pkg::*;

    localparam int NUM_LINES   = NUM_PORTS * PORT_W;
    localparam int NUM_GROUPS  = NUM_LINES / GROUP_W;
    localparam int NUM_PU_REGS = (NUM_GROUPS + PORT_W - 1) / PORT_W;
    localparam logic [NUM_LINES-1:0] IN_MASK = NUM_LINES'(1) << INONLY_LINE;

    typedef struct packed {
        logic [NUM_LINES-1:0]  dir;
        logic [NUM_LINES-1:0]  lat;
        logic [NUM_GROUPS-1:0] pull;
        logic                  ctrl;
    } regs_t;

    regs_t                regs_d, regs_q;
    acc_dec_t             dec;
    logic [NUM_LINES-1:0] locked;
    logic [PORT_W-1:0]    wmask;

    always_comb begin
        regs_d = regs_q;
        dec    = decode_addr(32'(addr_i), NUM_PORTS, NUM_PU_REGS);
        locked = (exp_mode_i ? BUS_LINES : '0) | IN_MASK;
        wmask  = '0;
        if (we_i) begin
            case (dec.kind)
                ACC_DATA: begin
                    for (int p = 0; p < NUM_PORTS; p++) begin
                        if (dec.idx == 8'(p)) regs_d.lat[p*PORT_W +: PORT_W] = wdata_i;
                    end
                end
                ACC_DIR: begin
                    for (int p = 0; p < NUM_PORTS; p++) begin
                        if (dec.idx == 8'(p)) begin
                            wmask = ~locked[p*PORT_W +: PORT_W];
                            regs_d.dir[p*PORT_W +: PORT_W] =
                                (regs_q.dir[p*PORT_W +: PORT_W] & ~wmask) | (wdata_i & wmask);
                        end
                    end
                end
                ACC_PULL: begin
                    for (int g = 0; g < NUM_GROUPS; g++) begin
                        if (dec.idx == 8'(g / PORT_W)) regs_d.pull[g] = wdata_i[g % PORT_W];
                    end
                end
                ACC_CTRL: regs_d.ctrl = wdata_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign dir_o  = regs_q.dir;
    assign lat_o  = regs_q.lat;
    assign pull_o = regs_q.pull;
    assign ctrl_o = regs_q.ctrl;

    // Bus-pin direction bits do not move while expansion mode is active
    assert_dir_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exp_mode_i |=> (((regs_q.dir ^ $past(regs_q.dir)) & BUS_LINES) == '0));

    // The input-only line never acquires a direction bit
    assert_inonly_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (regs_q.dir[INONLY_LINE] == 1'b0));
endmodule

// File: rtl/gpio_bank_pad.sv
module gpio_bank_pad #(
    parameter int NUM_LINES   = 32,
    parameter int GROUP_W     = 4,
    parameter logic [NUM_LINES-1:0] BUS_LINES = 'hFFFF,
    parameter int INONLY_LINE = 29
) (
    input  logic [NUM_LINES-1:0]         dir_i,
    input  logic [NUM_LINES-1:0]         lat_i,
    input  logic [NUM_LINES/GROUP_W-1:0] pull_i,
    input  logic                         exp_mode_i,
    input  logic [NUM_LINES-1:0]         periph_en_i,
    input  logic [NUM_LINES-1:0]         periph_out_i,
    output logic [NUM_LINES-1:0]         oe_o,
    output logic [NUM_LINES-1:0]         out_o,
    output logic [NUM_LINES-1:0]         pu_o
);
    localparam logic [NUM_LINES-1:0] IN_MASK = NUM_LINES'(1) << INONLY_LINE;

    logic [NUM_LINES-1:0] grp_pull;
    logic [NUM_LINES-1:0] bus_off;

    always_comb begin
        for (int l = 0; l < NUM_LINES; l++) grp_pull[l] = pull_i[l / GROUP_W];
        bus_off = exp_mode_i ? BUS_LINES : '0;
        oe_o    = (periph_en_i | dir_i) & ~IN_MASK;
        out_o   = ((periph_en_i & periph_out_i) | (~periph_en_i & lat_i)) & ~IN_MASK;
        pu_o    = grp_pull & ~dir_i & ~periph_en_i & ~bus_off & ~IN_MASK;
    end
endmodule

// File: rtl/gpio_bank_rdmux.sv
module gpio_bank_rdmux #(
    parameter int NUM_PORTS   = 4,
    parameter int PORT_W      = 8,
    parameter int GROUP_W     = 4,
    parameter int ADDR_W      = 6,
    parameter int LATCH_PORT  = 1,
    parameter int INONLY_LINE = 29
) (
    input  logic [ADDR_W-1:0]                    addr_i,
    input  logic [NUM_PORTS*PORT_W-1:0]          pin_sync_i,
    input  logic [NUM_PORTS*PORT_W-1:0]          dir_i,
    input  logic [NUM_PORTS*PORT_W-1:0]          lat_i,
    input  logic [NUM_PORTS*PORT_W/GROUP_W-1:0]  pull_i,
    input  logic                                 ctrl_i,
    output logic [PORT_W-1:0]                    rdata_o
);
    import gpio_bank_pkg::*;

    localparam int NUM_LINES   = NUM_PORTS * PORT_W;
    localparam int NUM_GROUPS  = NUM_LINES / GROUP_W;
    localparam int NUM_PU_REGS = (NUM_GROUPS + PORT_W - 1) / PORT_W;
    localparam int PU_BITS     = NUM_PU_REGS * PORT_W;
    localparam logic [NUM_LINES-1:0] IN_MASK    = NUM_LINES'(1) << INONLY_LINE;
    localparam logic [NUM_LINES-1:0] LATCH_MASK =
        {{(NUM_LINES-PORT_W){1'b0}}, {PORT_W{1'b1}}} << (LATCH_PORT * PORT_W);

    acc_dec_t             dec;
    logic [NUM_LINES-1:0] use_lat;
    logic [NUM_LINES-1:0] view;
    logic [PU_BITS-1:0]   pull_pad;

    always_comb begin
        dec      = decode_addr(32'(addr_i), NUM_PORTS, NUM_PU_REGS);
        use_lat  = (dir_i | (ctrl_i ? LATCH_MASK : '0)) & ~IN_MASK;
        view     = (lat_i & use_lat) | (pin_sync_i & ~use_lat);
        pull_pad = PU_BITS'(pull_i);
        rdata_o  = '0;
        case (dec.kind)
            ACC_DATA: begin
                for (int p = 0; p < NUM_PORTS; p++)
                    if (dec.idx == 8'(p)) rdata_o = view[p*PORT_W +: PORT_W];
            end
            ACC_DIR: begin
                for (int p = 0; p < NUM_PORTS; p++)
                    if (dec.idx == 8'(p)) rdata_o = dir_i[p*PORT_W +: PORT_W];
            end
            ACC_PULL: begin
                for (int k = 0; k < NUM_PU_REGS; k++)
                    if (dec.idx == 8'(k)) rdata_o = pull_pad[k*PORT_W +: PORT_W];
            end
            ACC_CTRL: rdata_o = {{(PORT_W-1){1'b0}}, ctrl_i};
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
    parameter int NUM_PORTS   = 4,
    parameter int PORT_W      = 8,
    parameter int GROUP_W     = 4,
    parameter int ADDR_W      = 6,
    parameter logic [NUM_PORTS*PORT_W-1:0] BUS_LINES = 'hFFFF,
    parameter int LATCH_PORT  = 1,
    parameter int INONLY_LINE = 29
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          we,
    input  logic [PORT_W-1:0]             wdata,
    output logic [PORT_W-1:0]             rdata,
    input  logic                          exp_mode,
    input  logic [NUM_PORTS*PORT_W-1:0]   periph_en,
    input  logic [NUM_PORTS*PORT_W-1:0]   periph_out,
    input  logic [NUM_PORTS*PORT_W-1:0]   pin_in,
    output logic [NUM_PORTS*PORT_W-1:0]   pin_oe,
    output logic [NUM_PORTS*PORT_W-1:0]   pin_out,
    output logic [NUM_PORTS*PORT_W-1:0]   pin_pu
);
    localparam int NUM_LINES  = NUM_PORTS * PORT_W;
    localparam int NUM_GROUPS = NUM_LINES / GROUP_W;
    localparam logic [NUM_LINES-1:0] IN_MASK = NUM_LINES'(1) << INONLY_LINE;

    logic [NUM_LINES-1:0]  dir_w, lat_w, pin_sync_w;
    logic [NUM_GROUPS-1:0] pull_w;
    logic                  ctrl_w;

    gpio_bank_sync #(.WIDTH(NUM_LINES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_in),
        .sync_o (pin_sync_w)
    );

    gpio_bank_regs #(
        .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .GROUP_W(GROUP_W), .ADDR_W(ADDR_W),
        .BUS_LINES(BUS_LINES), .INONLY_LINE(INONLY_LINE)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr),
        .we_i       (we),
        .wdata_i    (wdata),
        .exp_mode_i (exp_mode),
        .dir_o      (dir_w),
        .lat_o      (lat_w),
        .pull_o     (pull_w),
        .ctrl_o     (ctrl_w)
    );

    gpio_bank_pad #(
        .NUM_LINES(NUM_LINES), .GROUP_W(GROUP_W),
        .BUS_LINES(BUS_LINES), .INONLY_LINE(INONLY_LINE)
    ) pad_i (
        .dir_i        (dir_w),
        .lat_i        (lat_w),
        .pull_i       (pull_w),
        .exp_mode_i   (exp_mode),
        .periph_en_i  (periph_en),
        .periph_out_i (periph_out),
        .oe_o         (pin_oe),
        .out_o        (pin_out),
        .pu_o         (pin_pu)
    );

    gpio_bank_rdmux #(
        .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .GROUP_W(GROUP_W), .ADDR_W(ADDR_W),
        .LATCH_PORT(LATCH_PORT), .INONLY_LINE(INONLY_LINE)
    ) rdmux_i (
        .addr_i     (addr),
        .pin_sync_i (pin_sync_w),
        .dir_i      (dir_w),
        .lat_i      (lat_w),
        .pull_i     (pull_w),
        .ctrl_i     (ctrl_w),
        .rdata_o    (rdata)
    );

    // Pull-up is never requested on a driven line
    assert_pull_not_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

    // Bus pins carry no pull-up in expansion mode
    assert_pull_off_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exp_mode |-> ((pin_pu & BUS_LINES) == '0));

    // Active peripheral output owns the line
    assert_periph_owns_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((periph_en & ~IN_MASK & (~pin_oe | (pin_out ^ periph_out))) == '0));

    // Input-only line is never driven nor pulled
    assert_inonly_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe[INONLY_LINE] && !pin_pu[INONLY_LINE] && !pin_out[INONLY_LINE]);
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb_top;
    localparam int NP = 6;
    localparam int PW = 8;
    localparam int GW = 4;
    localparam int AW = 6;
    localparam int NL = NP * PW;
    localparam int NG = NL / GW;
    localparam int LP = 1;
    localparam int IN = 45;
    localparam logic [NL-1:0] BUS = 48'h0000_000F_FFFF;
    localparam logic [NL-1:0] INM = NL'(1) << IN;
    localparam int A_DIR = NP;
    localparam int A_PU  = 2 * NP;
    localparam int A_CTL = 2 * NP + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [PW-1:0] wdata = '0;
    logic [PW-1:0] rdata;
    logic          exp_mode = 1'b0;
    logic [NL-1:0] periph_en = '0, periph_out = '0;
    logic [NL-1:0] ext_en = '0, ext_val = '0;
    logic [NL-1:0] pin_in, pin_oe, pin_out, pin_pu;

    logic [NL-1:0] m_dir = '0, m_lat = '0;
    logic [NG-1:0] m_pu = '0;
    logic          m_ctl = 1'b0;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    // Pad model: driven value, else external drive, else pull-up level (open reads 0)
    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_en & ext_val) | (~pin_oe & ~ext_en & pin_pu);

    gpio_bank #(
        .NUM_PORTS(NP), .PORT_W(PW), .GROUP_W(GW), .ADDR_W(AW),
        .BUS_LINES(BUS), .LATCH_PORT(LP), .INONLY_LINE(IN)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata),
        .exp_mode(exp_mode), .periph_en(periph_en), .periph_out(periph_out),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
    );

    function automatic logic [NL-1:0] m_oe();
        return (periph_en | m_dir) & ~INM;
    endfunction

    function automatic logic [NL-1:0] m_out();
        return ((periph_en & periph_out) | (~periph_en & m_lat)) & ~INM;
    endfunction

    function automatic logic [NL-1:0] m_pull();
        logic [NL-1:0] g;
        for (int l = 0; l < NL; l++) g[l] = m_pu[l / GW];
        return g & ~m_dir & ~periph_en & ~(exp_mode ? BUS : '0) & ~INM;
    endfunction

    function automatic logic [NL-1:0] m_pad();
        logic [NL-1:0] oe = m_oe();
        return (oe & m_out()) | (~oe & ext_en & ext_val) | (~oe & ~ext_en & m_pull());
    endfunction

    function automatic logic [PW-1:0] exp_read(input int a);
        logic [NL-1:0] pad = m_pad();
        logic [PW-1:0] r = '0;
        logic [15:0]   pu16 = 16'(m_pu);
        if (a < NP) begin
            for (int b = 0; b < PW; b++) begin
                int l = a * PW + b;
                if (l == IN) r[b] = pad[l];
                else if ((a == LP && m_ctl) || m_dir[l]) r[b] = m_lat[l];
                else r[b] = pad[l];
            end
        end else if (a < A_PU) r = m_dir[(a - A_DIR)*PW +: PW];
        else if (a < A_CTL) r = pu16[(a - A_PU)*PW +: PW];
        else if (a == A_CTL) r = {7'd0, m_ctl};
        return r;
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, expv);
        end
    endtask

    task automatic wr(input int a, input logic [PW-1:0] d);
        @(negedge clk);
        addr = AW'(a); wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        if (a < NP) m_lat[a*PW +: PW] = d;
        else if (a < A_PU) begin
            for (int b = 0; b < PW; b++) begin
                int l = (a - A_DIR) * PW + b;
                if (l != IN && !(exp_mode && BUS[l])) m_dir[l] = d[b];
            end
        end else if (a < A_CTL) begin
            for (int b = 0; b < PW; b++) begin
                int g = (a - A_PU) * PW + b;
                if (g < NG) m_pu[g] = d[b];
            end
        end else if (a == A_CTL) m_ctl = d[0];
    endtask

    task automatic rd_chk(input int a, input string what);
        @(negedge clk);
        addr = AW'(a);
        #1;
        chk(what, 64'(rdata), 64'(exp_read(a)));
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic pins_chk(input string what);
        chk({what, " oe"},  64'(pin_oe),  64'(m_oe()));
        chk({what, " out"}, 64'(pin_out), 64'(m_out()));
        chk({what, " pu"},  64'(pin_pu),  64'(m_pull()));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1 reset state
        pins_chk("R1 reset");
        for (int a = A_DIR; a <= A_CTL; a++) rd_chk(a, "R1 reset register");

        // R3 / R4 latch and read paths on port 0
        ext_en[7:0] = 8'hFF; ext_val[7:0] = 8'h3C;
        wr(0, 8'hA5); settle();
        rd_chk(0, "R4 input bits read pin");
        pins_chk("R3 latch written in input mode");
        wr(A_DIR, 8'hFF); settle();
        rd_chk(0, "R4 output bits read latch");
        chk("R3 pin_out drives latch", 64'(pin_out[7:0]), 64'h A5);
        chk("R3 pin_oe", 64'(pin_oe[7:0]), 64'hFF);

        // R6 pull-up groups on port 3 (groups 6,7)
        wr(A_PU, 8'h40); wr(A_DIR + 3, 8'h0C); settle();
        chk("R6 pull only on input lines of group", 64'(pin_pu[31:24]), 64'h03);
        rd_chk(3, "R6 pulled lines read high");
        pins_chk("R6 pins");

        // R5 latch readback override on port 1
        ext_en[15:8] = 8'hFF; ext_val[15:8] = 8'h0F;
        wr(1, 8'hF0); settle();
        rd_chk(1, "R5 override off reads pin");
        wr(A_CTL, 8'hFF); settle();
        rd_chk(1, "R5 override reads latch");
        rd_chk(A_CTL, "R2 control upper bits read zero");
        wr(A_CTL, 8'h00);

        // R7 / R8 expansion mode
        wr(A_PU, 8'hFF); wr(A_PU + 1, 8'hFF); wr(A_DIR, 8'h00);
        exp_mode = 1'b1;
        wr(A_DIR, 8'hFF); wr(A_DIR + 2, 8'hFF); settle();
        rd_chk(A_DIR, "R8 locked direction unchanged");
        rd_chk(A_DIR + 2, "R8 partly locked direction");
        chk("R7 no pull on bus lines", 64'(pin_pu[19:0]), 64'h0);
        pins_chk("R7 pins in expansion mode");
        wr(A_PU, 8'h5A); settle();
        rd_chk(A_PU, "R7 pull register writable in expansion mode");
        rd_chk(A_PU + 1, "R2 unused pull bits read zero");
        exp_mode = 1'b0;
        wr(A_DIR, 8'h81); wr(A_PU, 8'hFF); settle();
        rd_chk(A_DIR, "R8 direction writable again");
        pins_chk("R7 pins after expansion mode");

        // R9 peripheral override on port 4
        periph_en[39:32] = 8'h0F; periph_out[39:32] = 8'h05; settle();
        chk("R9 periph forces oe", 64'(pin_oe[39:32]), 64'h0F);
        chk("R9 periph value", 64'(pin_out[35:32]), 64'h5);
        chk("R9 pull off on periph lines", 64'(pin_pu[39:32]), 64'hF0);
        rd_chk(4, "R9 data read of periph lines");
        rd_chk(A_DIR + 4, "R9 direction unchanged");

        // R10 input-only line
        wr(A_DIR + 5, 8'hFF); ext_en[IN] = 1'b1; ext_val[IN] = 1'b1; settle();
        rd_chk(A_DIR + 5, "R10 direction bit reads zero");
        chk("R10 line undriven and unpulled", 64'({pin_oe[IN], pin_pu[IN], pin_out[IN]}), 64'h0);
        rd_chk(5, "R10 data bit reads pin");
        ext_val[IN] = 1'b0; settle();
        rd_chk(5, "R10 data bit follows pin");

        // R2 unmapped addresses
        rd_chk(A_CTL + 1, "R2 unmapped read");
        rd_chk(63, "R2 unmapped top read");

        // Random mix
        for (int i = 0; i < 500; i++) begin
            int op = int'($urandom_range(0, 9));
            if (op < 6) wr(int'($urandom_range(0, A_CTL + 1)), PW'($urandom));
            else if (op == 6) exp_mode = ~exp_mode;
            else if (op == 7) begin
                periph_en  = NL'({$urandom, $urandom}) & NL'({$urandom, $urandom});
                periph_out = NL'({$urandom, $urandom});
            end else begin
                ext_en  = NL'({$urandom, $urandom});
                ext_val = NL'({$urandom, $urandom});
            end
            settle();
            pins_chk("random R3 R6 R7 R9 R10 pins");
            rd_chk(int'($urandom_range(0, A_CTL + 2)), "random R4 R5 R8 read");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule